// File: doc/BRIEF.md
# Self-Checking Latin Square Check-Bit Encoder

This block computes the check bits of a single-error-correcting orthogonal Latin square code over a data word of m*m bits, producing 2m check bits. The default is m = 4: 16 data bits and 8 check bits. Each check bit is built from its own XOR tree with no shared gates. A single internal fault can therefore corrupt at most one check bit.

The check bits form two groups. Within the first group, and again within the second, every data bit appears exactly once. So the XOR of all check bits is always zero when no fault is present. The self-check relies on this property, and it needs no separate predictor. A two-rail checker takes the parity of each group as one rail. Equal rails (00 or 11) mean the word is good. Unequal rails raise the error flag.

A duplicate generator sees the same data. Whenever the flag is set, the output multiplexer forwards the duplicate's check bits instead of the primary's. The primary's bits are always visible on a separate raw output. The outputs can optionally be registered.

Top module: `ols_selfcheck_enc`

## Requirements
- R1: For i in 0..m-1, check bit i is the XOR of data bits i*m through i*m+m-1 (the row group).
- R2: For j in 0..m-1, check bit m+j is the XOR of data bits j, j+m, j+2m, ... (the column group, with stride m).
- R3: With a fault-free primary generator, the XOR of all bits of `chk_raw_o` is 0 and `err_o` is 0 for every data word.
- R4: The rails are r1 = parity of primary bits 0..m-1 and r2 = parity of primary bits m..2m-1. `err_o` is r1 XOR r2, so it is 1 exactly when a single primary check bit differs from its correct value.
- R5: When `err_o` is 0, `chk_o` equals `chk_raw_o`.
- R6: When `err_o` is 1, `chk_o` carries the duplicate generator's value, which equals the correct encoding of the data.
- R7: `chk_raw_o` always shows the primary generator's bits, including a faulty bit.
- R8: With REG_OUT = 1 (the default), all outputs appear one clock after the data is sampled, and an active-low asynchronous reset clears every output to 0.
- R9: Flipping any single data bit changes exactly two check bits: one in the row group and one in the column group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | M*M | Data word to encode |
| chk_o | output | 2*M | Selected check bits (primary, or duplicate on error) |
| chk_raw_o | output | 2*M | Primary generator check bits |
| err_o | output | 1 | Concurrent error flag from the two-rail checker |

## Verification
Fault detection and fallback selection happen in the same cycle. When a primary bit is wrong, the flag must rise, and in that same cycle the selected output must switch to the duplicate. The bench provokes this by forcing the primary check vector so that one chosen bit is stuck at 0 or at 1, while random and directed data words are applied. In each such cycle it judges three things against a bench reference encoder: the flag must equal whether the stuck value differs from the correct bit, the selected output must still match the reference, and the raw output must show the stuck bit.

// File: rtl/ols_enc_pkg.sv
package ols_enc_pkg;
  typedef enum logic {GRP_ROW = 1'b0, GRP_COL = 1'b1} chk_grp_e;

  function automatic int unsigned chk_bits(int unsigned m);
    return 2 * m;
  endfunction

  // data bit index of tap n for check bit g
  function automatic int unsigned tap_idx(int unsigned m, int unsigned g, int unsigned n);
    if (g < m) return g * m + n;
    return (g - m) + n * m;
  endfunction

  function automatic chk_grp_e grp_of(int unsigned m, int unsigned g);
    return (g < m) ? GRP_ROW : GRP_COL;
  endfunction
endpackage

// File: rtl/ols_chk_gen.sv
module ols_chk_gen
  import ols_enc_pkg::*;
#(
  parameter int unsigned M = 4,
  localparam int unsigned K  = M * M,
  localparam int unsigned NC = 2 * M
) (
  input  logic [K-1:0]  data_i,
  output logic [NC-1:0] chk_o
);
  // one private XOR tree per check bit: no gate sharing across bits
  for (genvar g = 0; g < NC; g++) begin : g_bit
    localparam chk_grp_e GRP = grp_of(M, g);
    logic [M-1:0] taps;
    for (genvar n = 0; n < M; n++) begin : g_tap
      if (GRP == GRP_ROW) begin : g_row
        assign taps[n] = data_i[g*M + n];
      end else begin : g_col
        assign taps[n] = data_i[(g-M) + n*M];
      end
    end
    assign chk_o[g] = ^taps;
  end
endmodule

// File: rtl/ols_two_rail_chk.sv
module ols_two_rail_chk #(
  parameter int unsigned NC = 8,
  localparam int unsigned HALF = NC / 2
) (
  input  logic [NC-1:0] chk_i,
  output logic [1:0]    rail_o,
  output logic          err_o
);
  logic r1, r2;
  assign r1     = ^chk_i[HALF-1:0];
  assign r2     = ^chk_i[NC-1:HALF];
  assign rail_o = {r2, r1};
  assign err_o  = rail_o[0] ^ rail_o[1];
endmodule

// File: rtl/ols_out_stage.sv
module ols_out_stage #(
  parameter int unsigned NC      = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] prim_i,
  input  logic [NC-1:0] dup_i,
  input  logic          err_i,
  output logic [NC-1:0] sel_o,
  output logic [NC-1:0] raw_o,
  output logic          err_o
);
  logic [NC-1:0] sel_d;
  assign sel_d = err_i ? dup_i : prim_i;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o <= '0;
        raw_o <= '0;
        err_o <= 1'b0;
      end else begin
        sel_o <= sel_d;
        raw_o <= prim_i;
        err_o <= err_i;
      end
    end
  end else begin : g_comb
    assign sel_o = sel_d;
    assign raw_o = prim_i;
    assign err_o = err_i;
  end
endmodule

// File: rtl/ols_selfcheck_enc.sv
module ols_selfcheck_enc
  import ols_enc_pkg::*;
#(
  parameter int unsigned M       = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned K  = M * M,
  localparam int unsigned NC = 2 * M
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [K-1:0]  data_i,
  output logic [NC-1:0] chk_o,
  output logic [NC-1:0] chk_raw_o,
  output logic          err_o
);
  logic [NC-1:0] prim_chk;
  logic [NC-1:0] dup_chk;
  logic [1:0]    rail;
  logic          err_raw;

  ols_chk_gen #(.M(M)) u_prim (.data_i(data_i), .chk_o(prim_chk));
  ols_chk_gen #(.M(M)) u_dup  (.data_i(data_i), .chk_o(dup_chk));

  ols_two_rail_chk #(.NC(NC)) u_chk (
    .chk_i (prim_chk),
    .rail_o(rail),
    .err_o (err_raw)
  );

  ols_out_stage #(.NC(NC), .REG_OUT(REG_OUT)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .prim_i(prim_chk),
    .dup_i (dup_chk),
    .err_i (err_raw),
    .sel_o (chk_o),
    .raw_o (chk_raw_o),
    .err_o (err_o)
  );

  assert_flag_parity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (^chk_raw_o));

  assert_pass_prim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> chk_o == chk_raw_o);

  assert_fallback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> chk_o != chk_raw_o);

  assert_sel_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^chk_o) == 1'b0);

  if (REG_OUT) begin : g_rst_chk
    assert_reset_clear_R8: assert property (@(posedge clk_i)
      !rst_ni |-> (chk_o == '0 && chk_raw_o == '0 && !err_o));
  end
endmodule

// File: tb/ols_selfcheck_enc_tb.sv
module ols_selfcheck_enc_tb;
  localparam int M  = 4;
  localparam int K  = M * M;
  localparam int NC = 2 * M;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [K-1:0]  data = '0;
  logic [NC-1:0] chk, chk_raw;
  logic          err;
  logic [NC-1:0] fval;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ols_selfcheck_enc #(.M(M), .REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data),
    .chk_o(chk), .chk_raw_o(chk_raw), .err_o(err)
  );

  function automatic logic [NC-1:0] ref_enc(logic [K-1:0] d);
    logic [NC-1:0] c = '0;
    for (int i = 0; i < M; i++)
      for (int n = 0; n < M; n++) begin
        c[i]   ^= d[i*M + n];
        c[M+i] ^= d[i + n*M];
      end
    return c;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [K-1:0] d);
    @(negedge clk);
    data = d;
    @(negedge clk);
  endtask

  task automatic clean_vec(logic [K-1:0] d);
    logic [NC-1:0] e;
    apply(d);
    e = ref_enc(d);
    check(chk_raw[M-1:0] == e[M-1:0], "R1", 32'(chk_raw), 32'(e));
    check(chk_raw[NC-1:M] == e[NC-1:M], "R2", 32'(chk_raw), 32'(e));
    check(!err && (^chk_raw) == 1'b0, "R3", 32'({err, chk_raw}), 32'(e));
    check(chk == chk_raw, "R5", 32'(chk), 32'(chk_raw));
  endtask

  task automatic fault_vec(logic [K-1:0] d, int idx, logic stuck);
    logic [NC-1:0] e;
    logic exp_err;
    e = ref_enc(d);
    fval = e;
    fval[idx] = stuck;
    exp_err = (stuck != e[idx]);
    @(negedge clk);
    data = d;
    force u_dut.prim_chk = fval;
    @(negedge clk);
    check(err == exp_err, "R4", 32'(err), 32'(exp_err));
    check(chk == e, "R6", 32'(chk), 32'(e));
    check(chk_raw == fval, "R7", 32'(chk_raw), 32'(fval));
    release u_dut.prim_chk;
  endtask

  initial begin
    logic [NC-1:0] a;
    logic [K-1:0]  d;
    void'($urandom(32'h5eed_0c1a));
    rst_n = 1'b0;
    data  = 16'hffff;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(chk == '0 && chk_raw == '0 && !err, "R8", 32'({err, chk_raw, chk}), 32'h0);
    rst_n = 1'b1;

    // latency: value appears one edge after data
    @(negedge clk);
    data = 16'h0001;
    #1;
    check(chk_raw == ref_enc(16'hffff), "R8", 32'(chk_raw), 32'(ref_enc(16'hffff)));
    @(negedge clk);
    check(chk_raw == ref_enc(16'h0001), "R8", 32'(chk_raw), 32'(ref_enc(16'h0001)));

    clean_vec('0);
    clean_vec('1);
    clean_vec(16'ha5a5);
    for (int b = 0; b < K; b++) clean_vec(K'(1) << b);
    for (int i = 0; i < 300; i++) clean_vec(K'($urandom()));

    // R9: single data-bit flip moves one row and one column bit
    for (int i = 0; i < 40; i++) begin
      int b;
      d = K'($urandom());
      b = int'($urandom_range(K - 1, 0));
      apply(d);
      a = chk;
      apply(d ^ (K'(1) << b));
      check($countones(a ^ chk) == 2 && $countones(a[M-1:0] ^ chk[M-1:0]) == 1,
            "R9", 32'(a ^ chk), 32'(ref_enc(d) ^ ref_enc(d ^ (K'(1) << b))));
    end

    // stuck-at faults on every primary bit, both polarities
    for (int idx = 0; idx < NC; idx++) begin
      fault_vec('0, idx, 1'b1);
      fault_vec('1, idx, 1'b0);
    end
    for (int i = 0; i < 200; i++)
      fault_vec(K'($urandom()), int'($urandom_range(NC - 1, 0)), 1'($urandom()));

    // recovery after release
    clean_vec(16'h3c96);

    // asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(chk == '0 && chk_raw == '0 && !err, "R8", 32'({err, chk_raw, chk}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule